// File: doc/BRIEF.md
# Clearable Presettable Bus Latch

A bank of transparent storage bits placed on a shared bus. While the gate input is high the stored word follows the data input. When the gate falls, the word present at that moment is captured and then held. Two active-low overrides act asynchronously on the stored word and ignore the gate and the data. The set override forces every bit to 1, and the reset override forces every bit to 0. When both overrides are low, the set override wins. All bits share the same gate and override controls. The width is a parameter with a default of 10 bits.

The output stage is modelled as a value bus plus a single drive-enable, so no tri-state net has to be resolved. When the active-low output enable is high, the drive-enable is low and the value bus rests at 0, which stands for high impedance. The stored word keeps changing under the overrides and the gate while the outputs are off, and the new word appears as soon as the outputs are enabled again.

Internally, a decoder turns the three storage controls into one of four named modes:
- MODE_SET forces all ones.
- MODE_CLEAR forces all zeros.
- MODE_PASS makes the latch transparent.
- MODE_HOLD keeps the stored word.

Mode transitions follow the inputs directly. Any mode goes to MODE_SET when the set override falls. It goes to MODE_CLEAR when the reset override falls while set is inactive. It goes to MODE_PASS, or to MODE_HOLD, when both overrides are inactive and the gate is high, or low. A transition from MODE_PASS to MODE_HOLD captures the data. A transition from MODE_SET or MODE_CLEAR to MODE_HOLD keeps the forced word.

Top module: `bus_latch_top`

## Requirements
- R1: With set_n and rst_n both high and gate high, the stored word equals din and follows every change of din.
- R2: When gate falls with both overrides inactive, the word on din at that moment is held for as long as gate stays low.
- R3: With set_n high and rst_n low, every stored bit is 0, whatever gate and din are.
- R4: With set_n low, every stored bit is 1, whatever gate and din are.
- R5: With set_n and rst_n both low, the stored bits are all 1, because set has priority over reset.
- R6: With oe_n high, y_en is 0 and y_val is all zeros (high impedance). With oe_n low, y_en is 1 and y_val equals the stored word.
- R7: Set, reset and capture all update the stored word while oe_n is high, and that word appears on y_val as soon as oe_n goes low.
- R8: With gate low and both overrides inactive, changes on din have no effect on the stored word.
- R9: When an override is released while gate is low, the forced word is kept. When it is released while gate is high, the stored word immediately equals din.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| set_n | input | 1 | Asynchronous set override, active low; has priority over rst_n |
| rst_n | input | 1 | Asynchronous reset override, active low |
| gate | input | 1 | Latch enable, active high; transparent while high, captures on fall |
| oe_n | input | 1 | Output enable, active low |
| din | input | WIDTH | Data input |
| y_val | output | WIDTH | Output value; stored word when enabled, zeros when in high impedance |
| y_en | output | 1 | Output drive-enable; 0 means high impedance |

## Verification
The hardest behaviour to show from the ports is a change of the stored word that happens while the outputs are in high impedance. This includes an override released with the gate low, and a capture followed by data changes. None of these is visible until oe_n falls, so the effect must be tracked without direct observation. The stimulus first makes the change with oe_n high, then changes din again, and only then re-enables the outputs. A reference model in the bench tracks the hidden word so that each re-enable is checked against it. Random vectors with a fixed seed, biased so that the overrides are asserted only rarely, mix all four modes. Directed steps cover the release of each override with the gate both low and high.

// File: rtl/bus_latch_pkg.sv
package bus_latch_pkg;

    typedef enum logic [1:0] {
        MODE_HOLD  = 2'd0,
        MODE_PASS  = 2'd1,
        MODE_CLEAR = 2'd2,
        MODE_SET   = 2'd3
    } latch_mode_e;

endpackage

// File: rtl/bus_latch_ctrl.sv
module bus_latch_ctrl
    import bus_latch_pkg::*;
(
    input  logic        set_n,
    input  logic        rst_n,
    input  logic        gate,
    output latch_mode_e mode
);

    // Priority: set over reset over gate.
    always_comb begin
        unique casez ({set_n, rst_n, gate})
            3'b0??:  mode = MODE_SET;
            3'b10?:  mode = MODE_CLEAR;
            3'b111:  mode = MODE_PASS;
            3'b110:  mode = MODE_HOLD;
            default: mode = MODE_HOLD;
        endcase
    end

endmodule

// File: rtl/bus_latch_store.sv
module bus_latch_store
    import bus_latch_pkg::*;
#(
    parameter int WIDTH = 10
) (
    input  latch_mode_e      mode,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] q
);

    localparam logic [WIDTH-1:0] ALL_ONES  = {WIDTH{1'b1}};
    localparam logic [WIDTH-1:0] ALL_ZEROS = {WIDTH{1'b0}};

    always_latch begin
        unique case (mode)
            MODE_SET:   q <= ALL_ONES;
            MODE_CLEAR: q <= ALL_ZEROS;
            MODE_PASS:  q <= din;
            MODE_HOLD:  ;
        endcase
    end

endmodule

// File: rtl/bus_latch_drive.sv
module bus_latch_drive #(
    parameter int WIDTH = 10
) (
    input  logic             oe_n,
    input  logic [WIDTH-1:0] q,
    output logic [WIDTH-1:0] y_val,
    output logic             y_en
);

    assign y_en = ~oe_n;

    // Per-bit gating: the value bus rests at zero when not driving.
    for (genvar b = 0; b < WIDTH; b++) begin : g_bit
        assign y_val[b] = q[b] & ~oe_n;
    end

endmodule

// File: rtl/bus_latch_top.sv
module bus_latch_top
    import bus_latch_pkg::*;
#(
    parameter int WIDTH = 10
) (
    input  logic             set_n,
    input  logic             rst_n,
    input  logic             gate,
    input  logic             oe_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] y_val,
    output logic             y_en
);

    localparam logic [WIDTH-1:0] ONES = {WIDTH{1'b1}};

    latch_mode_e      mode;
    logic [WIDTH-1:0] q;

    bus_latch_ctrl u_ctrl (
        .set_n (set_n),
        .rst_n (rst_n),
        .gate  (gate),
        .mode  (mode)
    );

    bus_latch_store #(.WIDTH(WIDTH)) u_store (
        .mode (mode),
        .din  (din),
        .q    (q)
    );

    bus_latch_drive #(.WIDTH(WIDTH)) u_drive (
        .oe_n  (oe_n),
        .q     (q),
        .y_val (y_val),
        .y_en  (y_en)
    );

    // Port-level checks spanning decoder, storage and output stage.
    always_comb begin
        if (!set_n && !oe_n)
            p_set_wins_r5: assert (y_val == ONES && y_en);  // R4, R5
        if (set_n && !rst_n && !oe_n)
            p_clear_zero_r3: assert (y_val == '0 && y_en);
        if (set_n && rst_n && gate && !oe_n)
            p_transparent_r1: assert (y_val == din);
        if (oe_n)
            p_hiz_r6: assert (!y_en && y_val == '0);
    end

endmodule

// File: tb/test_bus_latch_top.sv
module test_bus_latch_top;

    localparam int W = 10;
    localparam logic [W-1:0] ONES = {W{1'b1}};

    logic         clk = 1'b0;
    logic         set_n = 1'b1;
    logic         rst_n = 1'b0;
    logic         gate = 1'b0;
    logic         oe_n = 1'b1;
    logic [W-1:0] din = '0;
    logic [W-1:0] y_val;
    logic         y_en;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    logic [W-1:0] model = '0;

    always #2.5 clk = ~clk;

    bus_latch_top #(.WIDTH(W)) i_bus_latch_top (
        .set_n (set_n),
        .rst_n (rst_n),
        .gate  (gate),
        .oe_n  (oe_n),
        .din   (din),
        .y_val (y_val),
        .y_en  (y_en)
    );

    function automatic logic [W-1:0] next_word(input logic s, input logic r,
                                               input logic g, input logic [W-1:0] d,
                                               input logic [W-1:0] cur);
        if (!s)      return ONES;
        else if (!r) return '0;
        else if (g)  return d;
        else         return cur;
    endfunction

    task automatic check(input string tag);
        logic [W-1:0] exp_val = oe_n ? '0 : model;
        logic         exp_en  = ~oe_n;
        checks++;
        if (y_en !== exp_en || y_val !== exp_val) begin
            errors++;
            $display("FAIL %s: y_en=%0b y_val=%h expected y_en=%0b y_val=%h",
                     tag, y_en, y_val, exp_en, exp_val);
        end
    endtask

    task automatic apply(input logic s, input logic r, input logic g, input logic o,
                         input logic [W-1:0] d, input string tag);
        @(posedge clk);
        #1;
        set_n = s; rst_n = r; gate = g; oe_n = o; din = d;
        model = next_word(s, r, g, d, model);
        @(negedge clk);
        check(tag);
    endtask

    initial begin
        #1_000_000;
        if (!done) begin
            errors++;
            $display("FAIL watchdog: run hung, expected completion");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        // Reset state: reset override low, outputs enabled
        apply(1, 0, 0, 0, 10'h2A5, "R3 reset state");
        apply(1, 0, 1, 0, 10'h155, "R3 clear ignores gate/din");
        apply(0, 1, 0, 0, 10'h000, "R4 preset ones");
        apply(0, 1, 1, 0, 10'h0F0, "R4 preset ignores data");
        apply(0, 0, 1, 0, 10'h000, "R5 preset over clear");
        // Transparency and capture
        apply(1, 1, 1, 0, 10'h123, "R1 transparent");
        apply(1, 1, 1, 0, 10'h3C3, "R1 follows din");
        apply(1, 1, 0, 0, 10'h3C3, "R2 capture on fall");
        apply(1, 1, 0, 0, 10'h01E, "R8 din ignored while held");
        apply(1, 1, 0, 0, 10'h3FF, "R2 hold");
        // Output disable
        apply(1, 1, 0, 1, 10'h3FF, "R6 high impedance");
        apply(1, 1, 0, 0, 10'h000, "R6 drive stored");
        // Updates while disabled
        apply(0, 1, 0, 1, 10'h000, "R7 preset while off");
        apply(1, 1, 0, 1, 10'h0AA, "R9 release preset gate low off");
        apply(1, 1, 0, 0, 10'h0AA, "R7 preset visible on enable");
        apply(1, 0, 0, 1, 10'h155, "R7 clear while off");
        apply(1, 1, 0, 0, 10'h155, "R9 release clear gate low");
        apply(1, 1, 1, 1, 10'h2D2, "R7 pass while off");
        apply(1, 1, 0, 1, 10'h2D2, "R7 capture while off");
        apply(1, 1, 0, 1, 10'h111, "R8 din change while off");
        apply(1, 1, 0, 0, 10'h111, "R7 captured visible");
        // Release with gate high
        apply(1, 0, 1, 0, 10'h0C3, "R3 clear gate high");
        apply(1, 1, 1, 0, 10'h0C3, "R9 release clear gate high");
        apply(0, 1, 1, 0, 10'h035, "R4 preset gate high");
        apply(1, 1, 1, 0, 10'h035, "R9 release preset gate high");
        apply(0, 0, 0, 0, 10'h000, "R5 both low gate low");
        apply(1, 0, 0, 0, 10'h000, "R3 release preset keeps clear");
        // Random mix
        for (int i = 0; i < 400; i++) begin
            logic s = ($urandom_range(0, 9) != 0);
            logic r = ($urandom_range(0, 7) != 0);
            logic g = $urandom_range(0, 1);
            logic o = ($urandom_range(0, 3) == 0);
            logic [W-1:0] d = W'($urandom);
            apply(s, r, g, o, d, "R1-mix random (R8)");
        end
        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule